// File: doc/BRIEF.md
# Pump-Driven Pulse Record Streamer

This block sits between a record FIFO and a processor's 32-bit input port. Each FIFO entry describes one detected pulse. It holds a count of the thresholds the pulse crossed and, for every threshold, a 64-bit rise time and a 64-bit fall time. The streamer takes one record off the FIFO and serves its timestamps to the processor as 32-bit words. The processor requests each word through a software-driven pump line. Only the thresholds the pulse actually crossed are sent, so a burst is anywhere from 4 to 24 words long.

The processor raises the pump line to ask for the next word, reads the data port, then lowers the pump line to release that word. A flag stays high for as long as words of the current pulse remain to be served. A run-enable input freezes the whole streamer while it is low. While frozen, no record is taken and no pump request is served.

Top module: `pulse_streamer`

## Requirements
- R1: After reset, `have_words` is 0, `fifo_pop` is 0 and `word_out` is 0.
- R2: When no burst is in progress, `run_en` is 1 and `fifo_empty` is 0, the block pulses `fifo_pop` for one cycle and captures `fifo_rdata` as the current record. The FIFO is show-ahead: `fifo_rdata` is the head entry whenever `fifo_empty` is 0. No pop happens while a burst is in progress.
- R3: The crossed-threshold count is `fifo_rdata[2:0]`. A value above 6 is treated as 6. A burst has 4 words per crossed threshold. A count of 0 consumes the record, keeps `have_words` low and leaves `word_out` unchanged.
- R4: Threshold k (k = 0..5) has its rise time at bits [3+128k +: 64] and its fall time at bits [67+128k +: 64]. Words are sent starting from threshold 0, in this order for each threshold: rise upper half, rise lower half, fall upper half, fall lower half.
- R5: A rising `pump_in` makes `word_out` show the next word within four clock cycles. After that, `word_out` holds that value until the next served pump rise, including while `pump_in` is low.
- R6: The word position advances only after `pump_in` has been seen low. Holding `pump_in` high for any length of time yields exactly one word, and the following pump cycle yields the next word with none skipped.
- R7: `have_words` goes high in the cycle after the pop of a record with a nonzero count. It goes low a few cycles after `pump_in` falls following the last word of the burst.
- R8: While `run_en` is 0, no record is popped and a pump rise is not served, so `word_out` keeps its value. Once `run_en` returns to 1, the pending request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | 1 = run, 0 = freeze the streamer |
| pump_in | input | 1 | Asynchronous request line from software: rise = next word, fall = word read |
| fifo_empty | input | 1 | Record FIFO has no entry |
| fifo_rdata | input | 771 | Head record of the FIFO (count plus 6 rise/fall pairs) |
| fifo_pop | output | 1 | Single-cycle read strobe to the FIFO |
| word_out | output | 32 | Current 32-bit word for the processor |
| have_words | output | 1 | Words of the current pulse remain to be served |

## Verification
The bench builds the block with its defaults: six thresholds, 64-bit timestamps and 32-bit words. With these values the full 24-word burst is reachable, and so is the clamp of an out-of-range count of 7 down to six thresholds. The table feeds records with counts 1, 6, 3, 0, 7 and 2 back to back. This exercises burst lengths, the order of words within each threshold, and a zero-length record passing through silently. Directed cases cover a pump held high for many cycles, and a freeze applied both before a record is popped and during a pending pump request.

// File: rtl/pstream_pkg.sv
package pstream_pkg;

    localparam int DEF_NUM_THR = 6;
    localparam int DEF_TS_W    = 64;
    localparam int DEF_WORD_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_WAIT_LO = 2'd2
    } st_e;

    // Number of words in a burst for a given crossed count (count clamped to num_thr)
    function automatic int burst_words(int cnt, int num_thr, int words_per_thr);
        int c;
        c = (cnt > num_thr) ? num_thr : cnt;
        return c * words_per_thr;
    endfunction

endpackage

// File: rtl/pump_sync.sv
module pump_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/word_mux.sv
module word_mux #(
    parameter int NUM_THR = 6,
    parameter int TS_W    = 64,
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 3,
    parameter int IDX_W   = 5,
    parameter int REC_W   = CNT_W + NUM_THR * 2 * TS_W
) (
    input  logic [REC_W-1:0]  rec,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    localparam int WPE  = TS_W / WORD_W;   // words per edge timestamp
    localparam int WPT  = 2 * WPE;         // words per threshold
    localparam int MAXW = NUM_THR * WPT;

    logic [WORD_W-1:0] words [MAXW];

    // Slot g: threshold g/WPT, edge (rise 0, fall 1), upper part first
    for (genvar g = 0; g < MAXW; g++) begin : g_slot
        assign words[g] = rec[CNT_W + (g / WPT) * 2 * TS_W + ((g % WPT) / WPE) * TS_W
                              + (WPE - 1 - (g % WPE)) * WORD_W +: WORD_W];
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < MAXW; i++) begin
            if (idx == IDX_W'(i)) word = words[i];
        end
    end
endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl
    import pstream_pkg::*;
#(
    parameter int NUM_THR = 6,
    parameter int TS_W    = 64,
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 3,
    parameter int IDX_W   = 5,
    parameter int REC_W   = CNT_W + NUM_THR * 2 * TS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              pump_s,
    input  logic              fifo_empty,
    input  logic [REC_W-1:0]  fifo_rdata,
    input  logic [WORD_W-1:0] mux_word,
    output logic              fifo_pop,
    output logic [REC_W-1:0]  rec_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [WORD_W-1:0] word_out,
    output logic              have_words
);
    localparam int WPT = 2 * (TS_W / WORD_W);

    st_e              state;
    logic [IDX_W-1:0] last_q;
    int               nwords;

    assign nwords     = burst_words(int'(fifo_rdata[CNT_W-1:0]), NUM_THR, WPT);
    assign fifo_pop   = (state == ST_IDLE) && run_en && !fifo_empty;
    assign have_words = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx_q    <= '0;
            last_q   <= '0;
            word_out <= '0;
            rec_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fifo_pop) begin
                        rec_q <= fifo_rdata;
                        if (nwords != 0) begin
                            last_q <= IDX_W'(nwords - 1);
                            state  <= ST_WAIT_HI;
                        end
                    end
                end
                ST_WAIT_HI: begin
                    if (run_en && pump_s) begin
                        word_out <= mux_word;
                        state    <= ST_WAIT_LO;
                    end
                end
                ST_WAIT_LO: begin
                    if (run_en && !pump_s) begin
                        if (idx_q == last_q) begin
                            idx_q <= '0;
                            state <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            state <= ST_WAIT_HI;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BURST_FROM_POP: assert property (@(posedge clk) disable iff (rst)
        $rose(have_words) |-> $past(fifo_pop)); // R7

    AST_PAUSE_NO_POP: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !fifo_pop); // R8

    AST_WORD_NEEDS_PUMP: assert property (@(posedge clk) disable iff (rst)
        (word_out != $past(word_out)) |-> ($past(pump_s) && $past(run_en))); // R5

    AST_ADVANCE_PUMP_LOW: assert property (@(posedge clk) disable iff (rst)
        (idx_q != $past(idx_q)) |-> !$past(pump_s)); // R6

    AST_END_PUMP_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(have_words) |-> !$past(pump_s)); // R7

    AST_NO_POP_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        have_words |=> (!fifo_pop || !$past(have_words) || !have_words)); // R2
endmodule

// File: rtl/pulse_streamer.sv
module pulse_streamer
    import pstream_pkg::*;
#(
    parameter int NUM_THR = DEF_NUM_THR,
    parameter int TS_W    = DEF_TS_W,
    parameter int WORD_W  = DEF_WORD_W,
    localparam int CNT_W  = $clog2(NUM_THR + 1),
    localparam int MAXW   = NUM_THR * 2 * (TS_W / WORD_W),
    localparam int IDX_W  = $clog2(MAXW),
    localparam int REC_W  = CNT_W + NUM_THR * 2 * TS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              pump_in,
    input  logic              fifo_empty,
    input  logic [REC_W-1:0]  fifo_rdata,
    output logic              fifo_pop,
    output logic [WORD_W-1:0] word_out,
    output logic              have_words
);
    logic              pump_s;
    logic [REC_W-1:0]  rec_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] mux_word;

    pump_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pump_in),
        .sync_out (pump_s)
    );

    word_mux #(
        .NUM_THR(NUM_THR), .TS_W(TS_W), .WORD_W(WORD_W),
        .CNT_W(CNT_W), .IDX_W(IDX_W), .REC_W(REC_W)
    ) u_mux (
        .rec  (rec_q),
        .idx  (idx_q),
        .word (mux_word)
    );

    stream_ctrl #(
        .NUM_THR(NUM_THR), .TS_W(TS_W), .WORD_W(WORD_W),
        .CNT_W(CNT_W), .IDX_W(IDX_W), .REC_W(REC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .pump_s     (pump_s),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .mux_word   (mux_word),
        .fifo_pop   (fifo_pop),
        .rec_q      (rec_q),
        .idx_q      (idx_q),
        .word_out   (word_out),
        .have_words (have_words)
    );
endmodule

// File: tb/pulse_streamer_bench.sv
`timescale 1ns/1ps
module pulse_streamer_bench;
    localparam int REC_W = 3 + 6 * 128;
    localparam int NREC  = 6;
    localparam int CNTS [NREC] = '{1, 6, 3, 0, 7, 2};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run_en = 1'b1;
    logic             pump_in = 1'b0;
    logic             fifo_empty;
    logic [REC_W-1:0] fifo_rdata;
    logic             fifo_pop;
    logic [31:0]      word_out;
    logic             have_words;

    logic [REC_W-1:0] fmem [16];
    int wr = 0;
    int rd = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign fifo_empty = (wr == rd);
    assign fifo_rdata = fmem[rd % 16];

    always @(posedge clk) begin
        if (rst) rd <= 0;
        else if (fifo_pop) rd <= rd + 1;
    end

    pulse_streamer u_pulse_streamer (
        .clk(clk), .rst(rst), .run_en(run_en), .pump_in(pump_in),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .word_out(word_out), .have_words(have_words)
    );

    function automatic logic [63:0] ts(int r, int t, int e);
        return {16'hC0DE, 8'(r), 8'(t), 8'(e), 8'h5A, 16'(r * 97 + t * 13 + e)};
    endfunction

    function automatic logic [REC_W-1:0] make_rec(int r, int cnt);
        logic [REC_W-1:0] v;
        v = '0;
        v[2:0] = 3'(cnt);
        for (int t = 0; t < 6; t++)
            for (int e = 0; e < 2; e++)
                v[3 + t * 128 + e * 64 +: 64] = ts(r, t, e);
        return v;
    endfunction

    function automatic logic [31:0] exp_word(int r, int i);
        logic [63:0] v;
        v = ts(r, i / 4, (i % 4) / 2);
        return (i % 2 == 0) ? v[63:32] : v[31:0];
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(int r, int cnt);
        fmem[wr % 16] = make_rec(r, cnt);
        wr++;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pump_word(int r, int i, string req);
        pump_in = 1'b1;
        wait_n(5);
        check(req, 64'(word_out), 64'(exp_word(r, i)));
        check("R7 have during burst", 64'(have_words), 64'd1);
        pump_in = 1'b0;
        wait_n(5);
        check("R5 word held after fall", 64'(word_out), 64'(exp_word(r, i)));
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        int rd_snap;
        logic [31:0] w_snap;
        run_en = 1'b0;
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state
        check("R1 have", 64'(have_words), 64'd0);
        check("R1 pop", 64'(fifo_pop), 64'd0);
        check("R1 word", 64'(word_out), 64'd0);
        run_en = 1'b1;

        // Table walk: records back to back (R2 R3 R4)
        for (int r = 0; r < NREC; r++) push(r, CNTS[r]);
        for (int r = 0; r < NREC; r++) begin
            int eff;
            eff = (CNTS[r] > 6) ? 6 : CNTS[r];
            if (eff == 0) continue;
            wait_n(4);
            check("R7 have at burst start", 64'(have_words), 64'd1);
            for (int i = 0; i < eff * 4; i++) pump_word(r, i, "R4 word order");
        end
        wait_n(5);
        check("R7 have low after last word", 64'(have_words), 64'd0);
        check("R2 every record popped once", 64'(rd), 64'(NREC));

        // R3 zero-count record alone
        w_snap = word_out;
        push(20, 0);
        wait_n(10);
        check("R3 zero count no burst", 64'(have_words), 64'd0);
        check("R3 zero count consumed", 64'(rd), 64'(NREC + 1));
        check("R3 zero count word unchanged", 64'(word_out), 64'(w_snap));

        // R6 pump held high yields one word
        push(10, 1);
        wait_n(4);
        pump_in = 1'b1;
        wait_n(30);
        check("R6 held pump first word", 64'(word_out), 64'(exp_word(10, 0)));
        pump_in = 1'b0;
        wait_n(5);
        for (int i = 1; i < 4; i++) pump_word(10, i, "R6 next word not skipped");
        wait_n(5);
        check("R7 have low after held burst", 64'(have_words), 64'd0);

        // R8 pause before pop and during pending pump
        run_en = 1'b0;
        rd_snap = rd;
        push(11, 2);
        wait_n(10);
        check("R8 no pop while paused", 64'(rd), 64'(rd_snap));
        check("R8 have low while paused", 64'(have_words), 64'd0);
        run_en = 1'b1;
        wait_n(5);
        check("R2 pop after resume", 64'(rd), 64'(rd_snap + 1));
        check("R7 have after resume", 64'(have_words), 64'd1);
        run_en = 1'b0;
        pump_in = 1'b1;
        wait_n(8);
        check("R8 pump not served while paused", 64'(word_out), 64'(exp_word(10, 3)));
        run_en = 1'b1;
        wait_n(5);
        check("R8 pump served after resume", 64'(word_out), 64'(exp_word(11, 0)));
        pump_in = 1'b0;
        wait_n(5);
        for (int i = 1; i < 8; i++) pump_word(11, i, "R5 word after pause");
        wait_n(5);
        check("R7 have low at end", 64'(have_words), 64'd0);

        done = 1'b1;
        report();
    end
endmodule